// File: doc/BRIEF.md
# Byte-Access Bridge to Word-Only Memory

This block lets a requester that works in byte addresses use a memory that can only read or write whole 32-bit words. Each request carries a byte address, a size code (byte, halfword or word), a direction, a sign-extension flag and, for stores, the write data. The bridge takes one request at a time on a valid/ready handshake. It answers with a single-cycle response that carries the load data and an error code.

The memory address is the byte address with its two low bits dropped. A narrow load reads the containing word, rotates it so the addressed lane sits at bit 0, masks it to the access width, and then zero-extends or sign-extends it. A narrow store reads the containing word, replaces only the addressed lane and writes the word back. An aligned word access goes to memory once, with no rotate and no merge. A mode input chooses little-endian or big-endian lane placement. The bridge refuses any access below a configurable low-address boundary and any misaligned access, and neither kind reaches the memory.

Top module: `byte_bridge`

## Requirements
- R1: Every memory access of a request uses the word address equal to the request's byte address shifted right by two.
- R2: Size codes are 0 = byte, 1 = halfword, 2 = word. A load returns the addressed lane in the low bits. In little-endian mode (big_endian = 0), byte offset o occupies word bits 8o+7:8o, and a halfword at offset o has byte o as its low byte. In big-endian mode, byte offset o occupies bits 31-8o:24-8o, and a halfword at offset o has byte o as its high byte.
- R3: With req_signed = 0, a byte or halfword load is zero-extended to 32 bits.
- R4: With req_signed = 1, a byte or halfword load copies the top bit of the selected lane into all higher result bits.
- R5: A byte or halfword store does one word read followed by one word write. Only the addressed lane changes, and the other bytes keep their old values.
- R6: An aligned word load uses exactly one memory read. An aligned word store uses exactly one memory write and no read.
- R7: A halfword at an odd offset, a word at a nonzero offset, or size code 3 returns rsp_err = 1 in the cycle after acceptance and causes no memory access.
- R8: An address below guard_limit returns rsp_err = 2 in the cycle after acceptance and causes no memory access. This check takes priority over the alignment check.
- R9: req_ready is low from the cycle after a memory-using request is accepted until its response cycle, so only one request is in flight. A load responds 3 cycles after acceptance, a narrow store 4 cycles after, and a word store 2 cycles after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| big_endian | input | 1 | Lane placement mode, sampled when a request is accepted |
| guard_limit | input | 32 | Byte addresses below this value are refused |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| req_signed | input | 1 | Sign-extend a narrow load |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data, right-justified |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Load result, zero on stores and errors |
| rsp_err | output | 2 | 0 ok, 1 misaligned, 2 guard |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 30 | Word address |
| mem_wdata | output | 32 | Word write data |
| mem_rdata | input | 32 | Word read data, one cycle after a read strobe |

## Verification
The bench sweeps both endian modes, every size code, every byte offset, both directions and both extension settings against a byte-level model of memory. A wrong rotate amount in one mode would show up as a swapped lane. Sign extension taken from the wrong bit would give wrong high bits on lanes whose top bit is set. A merge mask that is off by one lane would corrupt a neighbouring byte, which the bench detects when it compares the stored word. The guard is tested right at its boundary and against misaligned addresses below it, where the wrong priority would report an alignment error. The bench also counts memory reads and writes, so a word store that still does a read, or a refused store that still writes, is caught.

// File: rtl/bb_pkg.sv
package bb_pkg;
  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_ALIGN = 2'd1,
    ERR_GUARD = 2'd2
  } bb_err_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_MERGE = 2'd2,
    ST_WRITE = 2'd3
  } bb_state_e;
endpackage

// File: rtl/bb_lane.sv
module bb_lane #(
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic [OFF_W-1:0]  off,
  input  logic [1:0]        size,
  input  logic              big_endian,
  output logic [OFF_W-1:0]  shift_bytes,
  output logic [DATA_W-1:0] lane_mask,
  output logic              misaligned
);
  int nb;

  always_comb begin
    nb = 1 << size;
    misaligned = (int'(size) > OFF_W) || ((int'(off) & (nb - 1)) != 0);
    if (big_endian) shift_bytes = OFF_W'(BYTES - nb - int'(off));
    else            shift_bytes = off;
    for (int i = 0; i < BYTES; i++)
      lane_mask[8*i +: 8] = (i < nb) ? 8'hFF : 8'h00;
  end
endmodule

// File: rtl/bb_load_fmt.sv
module bb_load_fmt #(
  parameter int DATA_W = 32,
  localparam int OFF_W = $clog2(DATA_W / 8)
) (
  input  logic [DATA_W-1:0] word,
  input  logic [OFF_W-1:0]  shift_bytes,
  input  logic [1:0]        size,
  input  logic              sgn,
  input  logic [DATA_W-1:0] lane_mask,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] rot;
  int sh;
  int top;

  always_comb begin
    sh  = 8 * int'(shift_bytes);
    rot = (word >> sh) | (word << (DATA_W - sh));
    top = (8 << size) - 1;
    if (top > DATA_W - 1) top = DATA_W - 1;
    result = rot & lane_mask;
    if (sgn && rot[top]) result = result | ~lane_mask;
  end
endmodule

// File: rtl/bb_store_merge.sv
module bb_store_merge #(
  parameter int DATA_W = 32,
  localparam int OFF_W = $clog2(DATA_W / 8)
) (
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] wdata,
  input  logic [OFF_W-1:0]  shift_bytes,
  input  logic [DATA_W-1:0] lane_mask,
  output logic [DATA_W-1:0] merged
);
  int sh;

  always_comb begin
    sh     = 8 * int'(shift_bytes);
    merged = (old_word & ~(lane_mask << sh)) | ((wdata & lane_mask) << sh);
  end
endmodule

// File: rtl/byte_bridge.sv
module byte_bridge #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int OFF_W = $clog2(DATA_W / 8),
  localparam int WADDR_W = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               big_endian,
  input  logic [ADDR_W-1:0]  guard_limit,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [1:0]         req_size,
  input  logic               req_signed,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic [1:0]         rsp_err,
  output logic               mem_en,
  output logic               mem_we,
  output logic [WADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata
);
  import bb_pkg::*;

  bb_state_e         state;
  logic              c_write, c_sgn, c_be;
  logic [1:0]        c_size;
  logic [OFF_W-1:0]  c_off;
  logic [DATA_W-1:0] c_wdata;

  logic [OFF_W-1:0]  rq_shift, cp_shift;
  logic [DATA_W-1:0] rq_mask, cp_mask;
  logic              rq_mis, cp_mis;
  logic [DATA_W-1:0] load_val, merge_val;
  logic              accept, guard_hit, full_store;

  bb_lane #(.DATA_W(DATA_W)) u_lane_req (
    .off(req_addr[OFF_W-1:0]), .size(req_size), .big_endian(big_endian),
    .shift_bytes(rq_shift), .lane_mask(rq_mask), .misaligned(rq_mis));

  bb_lane #(.DATA_W(DATA_W)) u_lane_cap (
    .off(c_off), .size(c_size), .big_endian(c_be),
    .shift_bytes(cp_shift), .lane_mask(cp_mask), .misaligned(cp_mis));

  bb_load_fmt #(.DATA_W(DATA_W)) u_load (
    .word(mem_rdata), .shift_bytes(cp_shift), .size(c_size), .sgn(c_sgn),
    .lane_mask(cp_mask), .result(load_val));

  bb_store_merge #(.DATA_W(DATA_W)) u_merge (
    .old_word(mem_rdata), .wdata(c_wdata), .shift_bytes(cp_shift),
    .lane_mask(cp_mask), .merged(merge_val));

  assign req_ready  = (state == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign guard_hit  = req_addr < guard_limit;
  assign full_store = req_write && (int'(req_size) == OFF_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= ERR_NONE;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      c_write   <= 1'b0;
      c_sgn     <= 1'b0;
      c_be      <= 1'b0;
      c_size    <= '0;
      c_off     <= '0;
      c_wdata   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          c_write <= req_write;
          c_sgn   <= req_signed;
          c_be    <= big_endian;
          c_size  <= req_size;
          c_off   <= req_addr[OFF_W-1:0];
          c_wdata <= req_wdata;
          if (guard_hit || rq_mis) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= '0;
            rsp_err   <= guard_hit ? ERR_GUARD : ERR_ALIGN;
          end else begin
            mem_en    <= 1'b1;
            mem_we    <= full_store;
            mem_addr  <= req_addr[ADDR_W-1:OFF_W];
            mem_wdata <= req_wdata;
            state     <= full_store ? ST_WRITE : ST_READ;
          end
        end
        ST_READ:  state <= ST_MERGE;
        ST_MERGE: begin
          if (c_write) begin
            mem_en    <= 1'b1;
            mem_we    <= 1'b1;
            mem_wdata <= merge_val;
            state     <= ST_WRITE;
          end else begin
            rsp_valid <= 1'b1;
            rsp_rdata <= load_val;
            rsp_err   <= ERR_NONE;
            state     <= ST_IDLE;
          end
        end
        ST_WRITE: begin
          rsp_valid <= 1'b1;
          rsp_rdata <= '0;
          rsp_err   <= ERR_NONE;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/byte_bridge_chk.sv
module byte_bridge_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int WADDR_W = ADDR_W - 2
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  guard_limit,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_write,
  input logic [1:0]         req_size,
  input logic [ADDR_W-1:0]  req_addr,
  input logic               rsp_valid,
  input logic [1:0]         rsp_err,
  input logic               mem_en,
  input logic               mem_we,
  input logic [WADDR_W-1:0] mem_addr
);
  logic acc, low, bad_align, ok;
  logic [ADDR_W-1:0] seen_addr;

  assign acc       = req_valid && req_ready;
  assign low       = req_addr < guard_limit;
  assign bad_align = (req_size == 2'd3) || (req_size == 2'd1 && req_addr[0])
                     || (req_size == 2'd2 && req_addr[1:0] != 2'b00);
  assign ok        = !low && !bad_align;

  always_ff @(posedge clk) begin
    if (rst) seen_addr <= '0;
    else if (acc) seen_addr <= req_addr;
  end

  AST_WORD_ADDR: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> mem_addr == seen_addr[ADDR_W-1:2]); // R1
  AST_NARROW_RD_FIRST: assert property (@(posedge clk) disable iff (rst)
    acc && ok && req_write && req_size != 2'd2 |=> mem_en && !mem_we); // R5
  AST_WORD_ST_DIRECT: assert property (@(posedge clk) disable iff (rst)
    acc && ok && req_write && req_size == 2'd2 |=> mem_en && mem_we); // R6
  AST_ALIGN_REFUSE: assert property (@(posedge clk) disable iff (rst)
    acc && !low && bad_align |=> rsp_valid && rsp_err == 2'd1 && !mem_en); // R7
  AST_GUARD_REFUSE: assert property (@(posedge clk) disable iff (rst)
    acc && low |=> rsp_valid && rsp_err == 2'd2 && !mem_en); // R8
  AST_BUSY_WHILE_MEM: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> !req_ready); // R9
  AST_RSP_AFTER_MEM: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !mem_en); // R9
endmodule

bind byte_bridge byte_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .guard_limit(guard_limit), .req_valid(req_valid),
  .req_ready(req_ready), .req_write(req_write), .req_size(req_size),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr));

// File: tb/byte_bridge_test.sv
module byte_bridge_test;
  localparam int CLK_NS = 10;
  localparam int WORDS  = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        big_endian = 1'b0;
  logic [31:0] guard_limit = 32'd16;
  logic        req_valid = 1'b0, req_write = 1'b0, req_signed = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, rsp_valid, mem_en, mem_we;
  logic [31:0] rsp_rdata, mem_wdata;
  logic [1:0]  rsp_err;
  logic [29:0] mem_addr;
  logic [31:0] mem_rdata;

  logic [31:0] mem [WORDS];
  logic [31:0] exp_mem [WORDS];
  int rd_cnt, wr_cnt;
  int tests = 0, fails = 0;

  always #(CLK_NS/2) clk = ~clk;

  byte_bridge uut (
    .clk(clk), .rst(rst), .big_endian(big_endian), .guard_limit(guard_limit),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_signed(req_signed), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  function automatic logic [31:0] seed_word(int i);
    return 32'h9C3A_E517 ^ 32'(32'h0F1E_2D3C * i);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= seed_word(i);
      rd_cnt <= 0;
      wr_cnt <= 0;
      mem_rdata <= '0;
    end else if (mem_en) begin
      if (mem_we) begin
        mem[mem_addr[3:0]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr[3:0]];
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int lane_pos(logic be, logic [31:0] a);
    return be ? 3 - int'(a[1:0]) : int'(a[1:0]);
  endfunction

  function automatic logic [7:0] get_byte(logic be, logic [31:0] a);
    logic [31:0] w = exp_mem[a[5:2]];
    return w[8*lane_pos(be, a) +: 8];
  endfunction

  task automatic put_byte(logic be, logic [31:0] a, logic [7:0] v);
    exp_mem[a[5:2]][8*lane_pos(be, a) +: 8] = v;
  endtask

  task automatic run_req(input logic w, input logic [1:0] sz, input logic sg,
                         input logic [31:0] a, input logic [31:0] wd,
                         output logic [31:0] rd, output logic [1:0] er,
                         output int lat, output bit busy_ok);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_size = sz; req_signed = sg;
    req_addr = a; req_wdata = wd;
    lat = 0; busy_ok = 1'b1;
    do begin
      @(negedge clk);
      req_valid = 1'b0;
      lat++;
      if (!rsp_valid && req_ready) busy_ok = 1'b0;
    end while (!rsp_valid && lat < 20);
    rd = rsp_rdata; er = rsp_err;
  endtask

  initial begin
    #(CLK_NS * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd, a, wd, ex;
    logic [7:0]  b0, b1;
    logic [1:0]  er;
    int lat, r0, w0;
    bit busy;
    bit mis;

    for (int i = 0; i < WORDS; i++) exp_mem[i] = seed_word(i);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 reset ready", 32'(req_ready), 32'd1);
    check("R9 reset rsp", 32'(rsp_valid), 32'd0);
    check("R1 reset mem_en", 32'(mem_en), 32'd0);

    for (int be = 0; be < 2; be++) begin
      big_endian = be[0];
      for (int sz = 0; sz < 4; sz++)
        for (int off = 0; off < 4; off++)
          for (int w = 0; w < 2; w++)
            for (int sg = 0; sg < 2; sg++) begin
              a  = 32'(16 + 4 * ((sz * 4 + off + be * 5 + w * 3) % 12) + off);
              wd = 32'h5A6B_7C8D + 32'(32'h0111_1111 * (off + 4 * sz + sg));
              mis = (sz == 3) || (sz == 1 && off[0]) || (sz == 2 && off != 0);
              r0 = rd_cnt; w0 = wr_cnt;
              run_req(w[0], sz[1:0], sg[0], a, wd, rd, er, lat, busy);
              if (mis) begin
                check("R7 align err", 32'(er), 32'd1);
                check("R7 no access", 32'((rd_cnt - r0) + (wr_cnt - w0)), 32'd0);
                check("R7 latency", 32'(lat), 32'd1);
              end else if (w == 0) begin
                b0 = get_byte(be[0], a);
                b1 = get_byte(be[0], a + 1);
                if (sz == 0)      ex = sg ? {{24{b0[7]}}, b0} : {24'd0, b0};
                else if (sz == 1) begin
                  logic [15:0] h;
                  h  = be ? {b0, b1} : {b1, b0};
                  ex = sg ? {{16{h[15]}}, h} : {16'd0, h};
                end else ex = exp_mem[a[5:2]];
                if (sz == 2)   check("R2 R6 word load", rd, ex);
                else if (sg)   check("R2 R4 signed load", rd, ex);
                else           check("R2 R3 zero load", rd, ex);
                check("R6 load one read", 32'(rd_cnt - r0), 32'd1);
                check("R6 load no write", 32'(wr_cnt - w0), 32'd0);
                check("R9 load latency", 32'(lat), 32'd3);
                check("R9 busy during load", 32'(busy), 32'd1);
                check("R1 addr", 32'(mem_addr), 32'(a >> 2));
              end else begin
                if (sz == 0) put_byte(be[0], a, wd[7:0]);
                else if (sz == 1) begin
                  put_byte(be[0], a, be ? wd[15:8] : wd[7:0]);
                  put_byte(be[0], a + 1, be ? wd[7:0] : wd[15:8]);
                end else exp_mem[a[5:2]] = wd;
                check("R5 R6 stored word", mem[a[5:2]], exp_mem[a[5:2]]);
                check("R5 R6 write count", 32'(wr_cnt - w0), 32'd1);
                check("R5 R6 read count", 32'(rd_cnt - r0), (sz == 2) ? 32'd0 : 32'd1);
                check("R9 store latency", 32'(lat), (sz == 2) ? 32'd2 : 32'd4);
                check("R9 busy during store", 32'(busy), 32'd1);
                check("R1 store addr", 32'(mem_addr), 32'(a >> 2));
              end
            end
    end

    for (int ad = 0; ad < 16; ad++)
      for (int sz = 0; sz < 3; sz++) begin
        r0 = rd_cnt; w0 = wr_cnt;
        run_req(1'b1, sz[1:0], 1'b0, 32'(ad), 32'hFFFF_FFFF, rd, er, lat, busy);
        check("R8 guard err", 32'(er), 32'd2);
        check("R8 no access", 32'((rd_cnt - r0) + (wr_cnt - w0)), 32'd0);
        check("R8 latency", 32'(lat), 32'd1);
      end
    for (int i = 0; i < WORDS; i++) check("R8 memory intact", mem[i], exp_mem[i]);

    big_endian = 1'b0;
    run_req(1'b0, 2'd2, 1'b0, 32'd16, '0, rd, er, lat, busy);
    check("R8 boundary allowed", 32'(er), 32'd0);
    check("R8 boundary data", rd, exp_mem[4]);
    guard_limit = 32'd0;
    run_req(1'b0, 2'd0, 1'b0, 32'd2, '0, rd, er, lat, busy);
    check("R8 zero limit", 32'(er), 32'd0);
    check("R2 zero limit byte", rd, {24'd0, exp_mem[0][23:16]});

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule